// File: doc/BRIEF.md
# Vertical Field Timing Capture

This block measures the vertical timing of a video raster in units of lines. It receives single-cycle strobes marking horizontal sync events, vertical sync leading and trailing edges, and a level flag that is high while any colour channel carries active video. From every vertical leading edge a line counter counts horizontal sync events. During the field the block records four values: the line count at which vertical sync ends, the first and the last line that carried active video, and the total number of lines up to the next vertical leading edge.

At every vertical leading edge the values gathered in the field just ended move to four 16-bit output words in one step, and a publish strobe marks the move. The words then hold still for the whole next field, so a controller can read them at any time without tearing. The 12-bit line values sit in the upper bits of each word above four zero bits. The sync-width value fills only the upper byte. The block does not recognise interlace and does not separate composite sync.

Top module: `vfield_capture`

## Requirements
- R1: The line counter is set to 0 by a vertical leading strobe and goes up by one for each horizontal sync strobe. When both strobes arrive in the same cycle, the leading strobe wins.
- R2: The line counter saturates at 4095 and does not wrap. The published period word is then 16'hFFF0.
- R3: A vertical trailing strobe captures the current line count as the sync width, saturated to 255. The published width word carries this value in bits 15:8, with bits 7:0 zero. If no trailing strobe occurred in the field, the width word is 0.
- R4: A line counts as active if video_act was high in any cycle since the previous horizontal strobe, including the cycle of the strobe that closes the line. That line's number is the counter value when the closing strobe arrives. The first and last active lines of the field are published in bits 15:4, with bits 3:0 zero.
- R5: If a field has no active line, the first-line word is 16'hFFF0 and the last-line word is 16'h0000.
- R6: On a vertical leading strobe, all four words are updated together and pub_stb is high in the following cycle. At any other time the words keep their values. The period word holds the line count at the leading strobe in bits 15:4.
- R7: Video seen after the last horizontal strobe of a field and before the leading strobe does not count as an active line in either field.
- R8: After a synchronous reset, the words read width 0, first 16'hFFF0, last 0 and period 0, and pub_stb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_evt | input | 1 | One-cycle strobe per horizontal sync event |
| vs_lead | input | 1 | One-cycle strobe at the vertical sync leading edge |
| vs_trail | input | 1 | One-cycle strobe at the vertical sync trailing edge |
| video_act | input | 1 | High while any colour channel shows active video |
| pub_stb | output | 1 | High for one cycle after a publish |
| vwidth_word | output | 16 | Published sync width, upper byte |
| vfirst_word | output | 16 | Published first active line, left-justified |
| vlast_word | output | 16 | Published last active line, left-justified |
| vperiod_word | output | 16 | Published field period in lines, left-justified |

## Verification
The assertions assume that each strobe is high for one cycle at a time and that reset is held for at least one edge. They make no assumption about the spacing between strobes. The counting checks depend only on the order in which the strobes arrive. The stimulus drives every strobe at the falling clock edge for exactly one cycle. It puts idle cycles between horizontal strobes, and it places the trailing strobe and video pulses inside those idle cycles. This means the scoreboard can derive each field's expected words from the line indices alone.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  localparam int DEF_LINE_W = 12;
  localparam int DEF_WID_W  = 8;
  localparam int DEF_WORD_W = 16;
endpackage

// File: rtl/vfc_line_ctr.sv
module vfc_line_ctr #(
  parameter int LINE_W = vfc_pkg::DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_evt,
  input  logic              vs_lead,
  output logic [LINE_W-1:0] cnt
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (vs_lead)                 cnt <= '0;
    else if (hs_evt && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    vs_lead |=> cnt == '0); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!vs_lead && hs_evt && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R1
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (!vs_lead && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R2
endmodule

// File: rtl/vfc_width_cap.sv
module vfc_width_cap #(
  parameter int LINE_W = vfc_pkg::DEF_LINE_W,
  parameter int WID_W  = vfc_pkg::DEF_WID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vs_lead,
  input  logic              vs_trail,
  input  logic [LINE_W-1:0] cnt,
  output logic [WID_W-1:0]  width_hold
);
  localparam logic [LINE_W-1:0] WLIM = LINE_W'((1 << WID_W) - 1);

  logic [WID_W-1:0] width_sat;

  always_comb begin
    if (cnt > WLIM) width_sat = {WID_W{1'b1}};
    else            width_sat = cnt[WID_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           width_hold <= '0;
    else if (vs_lead)  width_hold <= '0;
    else if (vs_trail) width_hold <= width_sat;
  end

  AST_WIDTH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    vs_lead |=> width_hold == '0); // R3
endmodule

// File: rtl/vfc_act_track.sv
module vfc_act_track #(
  parameter int LINE_W = vfc_pkg::DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_evt,
  input  logic              vs_lead,
  input  logic              video_act,
  input  logic [LINE_W-1:0] cnt,
  output logic              seen,
  output logic [LINE_W-1:0] first_ln,
  output logic [LINE_W-1:0] last_ln
);
  logic line_hit;
  logic closes_active;

  assign closes_active = hs_evt && (line_hit || video_act);

  always_ff @(posedge clk) begin
    if (rst || vs_lead) begin
      line_hit <= 1'b0;
    end else if (hs_evt) begin
      line_hit <= 1'b0;
    end else if (video_act) begin
      line_hit <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || vs_lead) begin
      seen     <= 1'b0;
      first_ln <= '0;
      last_ln  <= '0;
    end else if (closes_active) begin
      seen    <= 1'b1;
      last_ln <= cnt;
      if (!seen) first_ln <= cnt;
    end
  end

  AST_ORDER: assert property (@(posedge clk) disable iff (rst)
    seen |-> first_ln <= last_ln); // R4
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
    vs_lead |=> !line_hit && !seen); // R7
endmodule

// File: rtl/vfc_result_bank.sv
module vfc_result_bank #(
  parameter int LINE_W = vfc_pkg::DEF_LINE_W,
  parameter int WID_W  = vfc_pkg::DEF_WID_W,
  parameter int WORD_W = vfc_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vs_lead,
  input  logic [LINE_W-1:0] cnt,
  input  logic [WID_W-1:0]  width_hold,
  input  logic              seen,
  input  logic [LINE_W-1:0] first_ln,
  input  logic [LINE_W-1:0] last_ln,
  output logic              pub_stb,
  output logic [WORD_W-1:0] width_word,
  output logic [WORD_W-1:0] first_word,
  output logic [WORD_W-1:0] last_word,
  output logic [WORD_W-1:0] period_word
);
  localparam int LPAD = WORD_W - LINE_W;
  localparam int WPAD = WORD_W - WID_W;
  localparam logic [WORD_W-1:0] NO_FIRST = {{LINE_W{1'b1}}, {LPAD{1'b0}}};

  logic [WORD_W-1:0] first_nx, last_nx;

  generate
    if (LPAD > 0) begin : g_pad
      assign first_nx = seen ? {first_ln, {LPAD{1'b0}}} : NO_FIRST;
      assign last_nx  = seen ? {last_ln,  {LPAD{1'b0}}} : '0;
    end else begin : g_nopad
      assign first_nx = seen ? first_ln : NO_FIRST;
      assign last_nx  = seen ? last_ln  : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pub_stb     <= 1'b0;
      width_word  <= '0;
      first_word  <= NO_FIRST;
      last_word   <= '0;
      period_word <= '0;
    end else begin
      pub_stb <= vs_lead;
      if (vs_lead) begin
        width_word  <= {width_hold, {WPAD{1'b0}}};
        first_word  <= first_nx;
        last_word   <= last_nx;
        period_word <= {cnt, {LPAD{1'b0}}};
      end
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vs_lead |=> $stable(width_word) && $stable(first_word)
                 && $stable(last_word) && $stable(period_word)); // R6
  AST_STROBE: assert property (@(posedge clk) disable iff (rst)
    vs_lead |=> pub_stb); // R6
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    pub_stb |-> period_word[3:0] == 4'h0 && first_word[3:0] == 4'h0
                && last_word[3:0] == 4'h0 && width_word[7:0] == 8'h00); // R3
  AST_NO_VIDEO: assert property (@(posedge clk) disable iff (rst)
    (vs_lead && !seen) |=> first_word == NO_FIRST && last_word == '0); // R5
endmodule

// File: rtl/vfield_capture.sv
module vfield_capture #(
  parameter int LINE_W = vfc_pkg::DEF_LINE_W,
  parameter int WID_W  = vfc_pkg::DEF_WID_W,
  parameter int WORD_W = vfc_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_evt,
  input  logic              vs_lead,
  input  logic              vs_trail,
  input  logic              video_act,
  output logic              pub_stb,
  output logic [WORD_W-1:0] vwidth_word,
  output logic [WORD_W-1:0] vfirst_word,
  output logic [WORD_W-1:0] vlast_word,
  output logic [WORD_W-1:0] vperiod_word
);
  logic [LINE_W-1:0] cnt;
  logic [WID_W-1:0]  width_hold;
  logic              seen;
  logic [LINE_W-1:0] first_ln, last_ln;

  vfc_line_ctr #(.LINE_W(LINE_W)) u_ctr (
    .clk(clk), .rst(rst), .hs_evt(hs_evt), .vs_lead(vs_lead), .cnt(cnt));

  vfc_width_cap #(.LINE_W(LINE_W), .WID_W(WID_W)) u_wid (
    .clk(clk), .rst(rst), .vs_lead(vs_lead), .vs_trail(vs_trail),
    .cnt(cnt), .width_hold(width_hold));

  vfc_act_track #(.LINE_W(LINE_W)) u_act (
    .clk(clk), .rst(rst), .hs_evt(hs_evt), .vs_lead(vs_lead),
    .video_act(video_act), .cnt(cnt), .seen(seen),
    .first_ln(first_ln), .last_ln(last_ln));

  vfc_result_bank #(.LINE_W(LINE_W), .WID_W(WID_W), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst(rst), .vs_lead(vs_lead), .cnt(cnt),
    .width_hold(width_hold), .seen(seen), .first_ln(first_ln),
    .last_ln(last_ln), .pub_stb(pub_stb), .width_word(vwidth_word),
    .first_word(vfirst_word), .last_word(vlast_word),
    .period_word(vperiod_word));
endmodule

// File: tb/sim_vfield_capture.sv
module sim_vfield_capture;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs_evt = 1'b0, vs_lead = 1'b0, vs_trail = 1'b0, video_act = 1'b0;
  logic pub_stb;
  logic [15:0] vwidth_word, vfirst_word, vlast_word, vperiod_word;

  typedef struct {
    logic [15:0] w;
    logic [15:0] f;
    logic [15:0] l;
    logic [15:0] p;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vfield_capture u0 (
    .clk(clk), .rst(rst), .hs_evt(hs_evt), .vs_lead(vs_lead),
    .vs_trail(vs_trail), .video_act(video_act), .pub_stb(pub_stb),
    .vwidth_word(vwidth_word), .vfirst_word(vfirst_word),
    .vlast_word(vlast_word), .vperiod_word(vperiod_word));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int m);
    return (v > m) ? m : v;
  endfunction

  // One field: n lines, trailing strobe in line w (w<0: none),
  // video in lines a..b (a<0: none), optional video after the last line.
  task automatic field(input int n, input int w, input int a, input int b, input bit tail);
    exp_t e;
    @(negedge clk) vs_lead = 1'b1;
    @(negedge clk) vs_lead = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < 3; g++) begin
        vs_trail  = (i == w && g == 0);
        video_act = (a >= 0 && i >= a && i <= b && g == 1);
        @(negedge clk);
      end
      vs_trail = 1'b0; video_act = 1'b0;
      hs_evt = 1'b1;
      @(negedge clk) hs_evt = 1'b0;
    end
    if (tail) begin
      video_act = 1'b1;
      @(negedge clk) video_act = 1'b0;
    end
    e.p = {12'(sat(n, 4095)), 4'h0};
    e.w = (w >= 0 && w < n) ? {8'(sat(w, 255)), 8'h00} : 16'h0000;
    e.f = (a >= 0) ? {12'(sat(a, 4095)), 4'h0} : 16'hFFF0;
    e.l = (a >= 0) ? {12'(sat(b, 4095)), 4'h0} : 16'h0000;
    exp_q.push_back(e);
    // mid-gap: words must still hold the previous publish
    @(negedge clk);
    chk("R6 hold width",  vwidth_word,  last_exp.w);
    chk("R6 hold period", vperiod_word, last_exp.p);
  endtask

  // Monitor: pops an expected item on each publish
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && pub_stb) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected publish", 16'h0001, 16'h0000);
        end else begin
          last_exp = exp_q.pop_front();
          chk("R6 R2 period", vperiod_word, last_exp.p);
          chk("R3 width",     vwidth_word,  last_exp.w);
          chk("R4 R5 first",  vfirst_word,  last_exp.f);
          chk("R4 R5 R7 last", vlast_word,  last_exp.l);
        end
      end
    end
  end

  initial begin
    last_exp.w = 16'h0000; last_exp.f = 16'hFFF0;
    last_exp.l = 16'h0000; last_exp.p = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset width",  vwidth_word,  16'h0000);
    chk("R8 reset first",  vfirst_word,  16'hFFF0);
    chk("R8 reset last",   vlast_word,   16'h0000);
    chk("R8 reset period", vperiod_word, 16'h0000);
    chk("R8 reset strobe", {15'h0, pub_stb}, 16'h0000);
    // empty stretch before the first leading strobe (R1 restart from reset)
    exp_q.push_back(last_exp);
    field(20, 3, 5, 12, 1'b1);        // R1 R3 R4, tail video for R7
    field(30, 6, -1, -1, 1'b0);       // R5, R7 (no leak of tail)
    field(10, -1, 0, 9, 1'b0);        // R3 no trailing strobe, R4 edges
    field(300, 280, 7, 7, 1'b0);      // R3 width saturation, single line
    field(4100, 2, 4097, 4099, 1'b0); // R2 saturation
    field(15, 4, 1, 14, 1'b0);        // R1 recovery after saturation
    @(negedge clk) vs_lead = 1'b1;
    @(negedge clk) vs_lead = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 queue drained", 16'(exp_q.size()), 16'h0000);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule